// File: doc/BRIEF.md
# Page-Mode Asynchronous SRAM Host Controller

This block sits between a clocked on-chip requester and a 16-bit asynchronous pseudo-static memory with two byte lanes. A request carries an address, byte enables, write data, a direction and a burst length. The controller turns it into strobe sequences on the memory's chip-select, output-enable, write-enable and byte-lane pins, and it drives a tri-state data bus. Every wait is a whole number of clock cycles. Each count is the matching timing value divided by the clock period, rounded up, and all of these values are parameters.

Reads return one word per response pulse. A read burst of 2 to 16 words stays inside one 16-word page. The first word waits the full access time. Each later word changes only the low four address bits and waits the shorter page time. If a burst would keep chip-select low longer than the maximum continuous-access time, the controller releases chip-select for the precharge gap and then resumes with a full-length first access. Writes are single words with a per-lane mask. A mask of all zeros runs the write cycle with both lanes off, so no data is stored.

States: `ST_IDLE` (ready, accepts or rejects), `ST_RD_FIRST` (full access wait), `ST_RD_PAGE` (page access wait), `ST_RD_BREAK` (chip-select high inside a long burst), `ST_WR_PULSE` (write strobe low), `ST_WR_HOLD` (write strobe high, data held), `ST_GAP` (chip-select high after an access). Transitions: IDLE→WR_PULSE on an accepted write; IDLE→RD_FIRST on an accepted read; IDLE→IDLE on a rejected request; RD_FIRST/RD_PAGE→GAP after the last word; RD_FIRST/RD_PAGE→RD_BREAK when another page word would overrun the continuous-access limit; RD_FIRST/RD_PAGE→RD_PAGE otherwise; RD_BREAK→RD_FIRST; WR_PULSE→WR_HOLD; WR_HOLD→GAP; GAP→IDLE.

Top module: `psram_page_ctrl`

## Requirements
- R1: A request whose length is 0, whose word offset (address bits 3:0) plus length exceeds 16, or that is a write with a length other than 1, is rejected. `rsp_valid` and `rsp_err` are high together for one cycle, in the cycle after acceptance, and chip-select stays high. A burst that ends exactly on the page's last word is accepted.
- R2: A read holds chip-select and output-enable low for FIRST_CYC cycles, with FIRST_CYC = max(ceil(T_AA/CLK_NS), ceil(T_RC/CLK_NS), ceil(T_OE/CLK_NS)) = 7 by default. It returns the word with a one-cycle `rsp_valid` and `rsp_err` low. The response comes FIRST_CYC+1 cycles after acceptance.
- R3: In a burst, address bits 22:4 stay constant while chip-select is low, and bits 3:0 step up by one per word. Each later word follows the previous one by PAGE_CYC = max(ceil(T_PAA/CLK_NS), ceil(T_PC/CLK_NS)) = 3 cycles. Words are returned in address order.
- R4: A write drives write data onto the bus and holds write-enable low for WR_CYC cycles inside a chip-select low window, with WR_CYC = max(ceil(T_WP/CLK_NS), ceil(T_AW/CLK_NS), ceil(T_DW/CLK_NS), ceil(T_WC/CLK_NS)-1) = 6 by default. It then keeps chip-select low, with data still driven, for one more cycle. Completion is a `rsp_valid` pulse with `rsp_err` low.
- R5: `req_be[0]` enables the low lane (`mem_lb_n`, data bits 7:0) and `req_be[1]` enables the high lane (`mem_ub_n`, data bits 15:8). On a read, a disabled lane returns zero. On a write, only enabled lanes change in memory.
- R6: A write with `req_be` = 00 stores nothing. It still completes with `rsp_valid` and `rsp_err` low.
- R7: Chip-select stays high for at least CP_CYC = max(1, ceil(T_CP/CLK_NS)) cycles between any two low windows.
- R8: Chip-select never stays low for more than MRC_CYC = floor(T_MRC/CLK_NS) consecutive cycles. A burst that would exceed this limit is split by a chip-select high gap, and each split resumes with a full first-access wait. All words are still returned correctly.
- R9: Write-enable and output-enable are never low together. The controller's bus drive is off for at least one cycle before output-enable falls.
- R10: `req_ready` is high only in the idle state, so it is low whenever chip-select is low.
- R11: After reset, chip-select, output-enable, write-enable and both lane enables are high. The bus is released, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address of the first word |
| req_be | input | 2 | Lane enables, bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| req_len | input | 5 | Burst length in words, 1 to 16 |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 16 | Read word, disabled lanes zero |
| mem_addr | output | 23 | Memory address |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_ub_n | output | 1 | High lane enable, active low |
| mem_lb_n | output | 1 | Low lane enable, active low |
| mem_dq | inout | 16 | Tri-state data bus |

## Verification
The bound checker watches the strobe rules on every cycle. It checks that write and output enables are never low together, that write-enable only falls inside chip-select, the minimum write-enable width, and that the bus drive is released before output-enable falls. It also checks the page-address stability, the precharge gap, the continuous-access limit and that the controller is not ready while an access is in progress. Data integrity cannot be seen from the pins alone, so only the bench scenarios show it. These cover lane masking, the write-abort, rejection of bad requests and exact response timing, and burst splitting under a short continuous-access limit, where the words must still come back in order.

// File: rtl/psram_ctrl_pkg.sv
`timescale 1ns/1ps
package psram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FIRST,
        ST_RD_PAGE,
        ST_RD_BREAK,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_GAP
    } ctrl_state_e;

    // Cycles needed to cover a time value, rounded up.
    function automatic int cyc_ceil(input int time_ns, input int clk_ns);
        return (time_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_cyc_timer.sv
`timescale 1ns/1ps
// Loadable down-counter; done is high while the count is zero.
module psram_cyc_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/psram_run_guard.sv
`timescale 1ns/1ps
// Counts consecutive chip-select-low cycles and flags when one more
// page step would push the run past the continuous-access limit.
module psram_run_guard #(
    parameter int GW    = 11,
    parameter int LIMIT = 2000,
    parameter int STEP  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_active,
    output logic near_limit
);
    localparam logic [GW-1:0] NEAR_AT = GW'(LIMIT - STEP);

    logic [GW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!cs_active) begin
            run_q <= '0;
        end else if (run_q != '1) begin
            run_q <= run_q + 1'b1;
        end
    end

    // run_q counts the earlier low cycles; the current one adds 1.
    assign near_limit = (run_q >= NEAR_AT);
endmodule

// File: rtl/psram_req_check.sv
`timescale 1ns/1ps
// Request legality: non-zero length, no page crossing, single-word writes.
module psram_req_check #(
    parameter int PAGE_WORDS = 16,
    parameter int PB         = 4,
    parameter int LEN_W      = 5
) (
    input  logic [PB-1:0]    offset,
    input  logic [LEN_W-1:0] len,
    input  logic             is_write,
    output logic             ok
);
    logic [LEN_W:0] span;

    assign span = (LEN_W+1)'(offset) + (LEN_W+1)'(len);
    assign ok   = (len != '0)
               && (span <= (LEN_W+1)'(PAGE_WORDS))
               && (!is_write || (len == LEN_W'(1)));
endmodule

// File: rtl/psram_page_ctrl.sv
`timescale 1ns/1ps
module psram_page_ctrl
    import psram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 23,
    parameter int DATA_W     = 16,
    parameter int PAGE_WORDS = 16,
    parameter int CLK_NS     = 10,
    parameter int T_AA       = 70,
    parameter int T_RC       = 70,
    parameter int T_OE       = 25,
    parameter int T_PAA      = 25,
    parameter int T_PC       = 25,
    parameter int T_WC       = 70,
    parameter int T_WP       = 50,
    parameter int T_AW       = 60,
    parameter int T_DW       = 20,
    parameter int T_CP       = 10,
    parameter int T_MRC      = 20000
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    output logic                                 req_ready,
    input  logic                                 req_write,
    input  logic [ADDR_W-1:0]                    req_addr,
    input  logic [DATA_W/8-1:0]                  req_be,
    input  logic [DATA_W-1:0]                    req_wdata,
    input  logic [$clog2(PAGE_WORDS+1)-1:0]      req_len,
    output logic                                 rsp_valid,
    output logic                                 rsp_err,
    output logic [DATA_W-1:0]                    rsp_rdata,
    output logic [ADDR_W-1:0]                    mem_addr,
    output logic                                 mem_cs_n,
    output logic                                 mem_oe_n,
    output logic                                 mem_we_n,
    output logic                                 mem_ub_n,
    output logic                                 mem_lb_n,
    inout  wire  [DATA_W-1:0]                    mem_dq
);
    localparam int BE_W  = DATA_W / 8;
    localparam int PB    = $clog2(PAGE_WORDS);
    localparam int LEN_W = $clog2(PAGE_WORDS + 1);

    localparam int FIRST_CYC = imax(imax(cyc_ceil(T_AA, CLK_NS), cyc_ceil(T_RC, CLK_NS)),
                                    cyc_ceil(T_OE, CLK_NS));
    localparam int PAGE_CYC  = imax(cyc_ceil(T_PAA, CLK_NS), cyc_ceil(T_PC, CLK_NS));
    localparam int WR_CYC    = imax(imax(cyc_ceil(T_WP, CLK_NS), cyc_ceil(T_AW, CLK_NS)),
                                    imax(cyc_ceil(T_DW, CLK_NS), cyc_ceil(T_WC, CLK_NS) - 1));
    localparam int CP_CYC    = imax(1, cyc_ceil(T_CP, CLK_NS));
    localparam int MRC_CYC   = T_MRC / CLK_NS;
    localparam int TMR_MAX   = imax(imax(FIRST_CYC, PAGE_CYC), imax(WR_CYC, CP_CYC));
    localparam int TW        = $clog2(TMR_MAX + 1);
    localparam int GW        = $clog2(MRC_CYC + 1);

    ctrl_state_e state_q, state_d;

    logic             tmr_load;
    logic [TW-1:0]    tmr_val;
    logic             tmr_done;
    logic             near_limit;
    logic             req_ok;
    logic             cs_active;
    logic             drive_dq;
    logic             capture;

    logic [ADDR_W-1:0] addr_q;
    logic [BE_W-1:0]   be_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LEN_W-1:0]  left_q;
    logic [DATA_W-1:0] rd_mask;

    psram_cyc_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    psram_run_guard #(.GW(GW), .LIMIT(MRC_CYC), .STEP(PAGE_CYC)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_active  (cs_active),
        .near_limit (near_limit)
    );

    psram_req_check #(.PAGE_WORDS(PAGE_WORDS), .PB(PB), .LEN_W(LEN_W)) u_check (
        .offset   (req_addr[PB-1:0]),
        .len      (req_len),
        .is_write (req_write),
        .ok       (req_ok)
    );

    for (genvar ln = 0; ln < BE_W; ln++) begin : g_lane
        assign rd_mask[8*ln +: 8] = {8{be_q[ln]}};
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && req_ok) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_PULSE;
                        tmr_val = TW'(WR_CYC - 1);
                    end else begin
                        state_d = ST_RD_FIRST;
                        tmr_val = TW'(FIRST_CYC - 1);
                    end
                end
            end
            ST_RD_FIRST, ST_RD_PAGE: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (left_q == LEN_W'(1)) begin
                        state_d = ST_GAP;
                        tmr_val = TW'(CP_CYC - 1);
                    end else if (near_limit) begin
                        state_d = ST_RD_BREAK;
                        tmr_val = TW'(CP_CYC - 1);
                    end else begin
                        state_d = ST_RD_PAGE;
                        tmr_val = TW'(PAGE_CYC - 1);
                    end
                end
            end
            ST_RD_BREAK: begin
                if (tmr_done) begin
                    state_d  = ST_RD_FIRST;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(FIRST_CYC - 1);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_done) state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_d  = ST_GAP;
                tmr_load = 1'b1;
                tmr_val  = TW'(CP_CYC - 1);
            end
            ST_GAP: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Strobe outputs decoded from the state
    always_comb begin
        cs_active = 1'b0;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        drive_dq  = 1'b0;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_RD_FIRST,
            ST_RD_PAGE: begin
                cs_active = 1'b1;
                mem_oe_n  = 1'b0;
            end
            ST_WR_PULSE: begin
                cs_active = 1'b1;
                mem_we_n  = 1'b0;
                drive_dq  = 1'b1;
            end
            ST_WR_HOLD: begin
                cs_active = 1'b1;
                drive_dq  = 1'b1;
            end
            ST_RD_BREAK, ST_GAP: ;
            default: ;
        endcase
    end

    assign mem_cs_n = !cs_active;
    assign mem_ub_n = !(cs_active && be_q[BE_W-1]);
    assign mem_lb_n = !(cs_active && be_q[0]);
    assign mem_addr = addr_q;
    assign mem_dq   = drive_dq ? wdata_q : {DATA_W{1'bz}};

    assign capture  = ((state_q == ST_RD_FIRST) || (state_q == ST_RD_PAGE)) && tmr_done;

    // Request capture, address stepping and responses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            be_q      <= '0;
            wdata_q   <= '0;
            left_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            if ((state_q == ST_IDLE) && req_valid) begin
                if (req_ok) begin
                    addr_q  <= req_addr;
                    be_q    <= req_be;
                    wdata_q <= req_wdata;
                    left_q  <= req_len;
                end else begin
                    rsp_valid <= 1'b1;
                    rsp_err   <= 1'b1;
                end
            end
            if (capture) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= mem_dq & rd_mask;
                left_q    <= left_q - 1'b1;
                if (left_q != LEN_W'(1)) begin
                    addr_q[PB-1:0] <= addr_q[PB-1:0] + 1'b1;
                end
            end
            if (state_q == ST_WR_HOLD) begin
                rsp_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/psram_page_ctrl_chk.sv
`timescale 1ns/1ps
module psram_page_ctrl_chk #(
    parameter int ADDR_W  = 23,
    parameter int PB      = 4,
    parameter int MRC_CYC = 2000,
    parameter int WR_CYC  = 6,
    parameter int CP_CYC  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              drive_dq
);
    int unsigned cs_run;
    int unsigned cs_high;
    int unsigned we_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_run  <= 0;
            cs_high <= CP_CYC;
            we_run  <= 0;
        end else begin
            cs_run  <= mem_cs_n ? 0 : cs_run + 1;
            cs_high <= mem_cs_n ? cs_high + 1 : 0;
            we_run  <= mem_we_n ? 0 : we_run + 1;
        end
    end

    a_r9_no_oe_we_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    a_r9_bus_released_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> $past(!drive_dq));

    a_r4_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run >= WR_CYC));

    a_r3_page_high_bits_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> (mem_addr[ADDR_W-1:PB] == $past(mem_addr[ADDR_W-1:PB])));

    a_r7_cs_high_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> (cs_high >= CP_CYC));

    a_r8_cs_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> (cs_run < MRC_CYC));

    a_r10_not_ready_when_active: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready);
endmodule

bind psram_page_ctrl psram_page_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .PB      (PB),
    .MRC_CYC (MRC_CYC),
    .WR_CYC  (WR_CYC),
    .CP_CYC  (CP_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .drive_dq  (drive_dq)
);

// File: tb/psram_page_ctrl_test.sv
`timescale 1ns/1ps
module psram_model (
    input  logic [22:0] a,
    input  logic        cs_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic        ub_n,
    input  logic        lb_n,
    inout  wire  [15:0] dq
);
    logic [15:0] mem [256];
    logic        rd;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'((i * 257) ^ 16'h5AC3);
    end

    assign rd       = !cs_n && !oe_n && we_n;
    assign dq[7:0]  = (rd && !lb_n) ? mem[a[7:0]][7:0]  : 8'hzz;
    assign dq[15:8] = (rd && !ub_n) ? mem[a[7:0]][15:8] : 8'hzz;

    always @(posedge we_n) begin
        if (!cs_n) begin
            if (!lb_n) mem[a[7:0]][7:0]  <= dq[7:0];
            if (!ub_n) mem[a[7:0]][15:8] <= dq[15:8];
        end
    end
endmodule

module psram_page_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [22:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic [4:0]  req_len = '0;
    logic        sel = 1'b0;

    logic        rdy0, rv0, re0, cs0, oe0, we0, ub0, lb0;
    logic [15:0] rd0;
    logic [22:0] a0;
    wire  [15:0] dq0;
    logic        rdy1, rv1, re1, cs1, oe1, we1, ub1, lb1;
    logic [15:0] rd1;
    logic [22:0] a1;
    wire  [15:0] dq1;

    psram_page_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid && !sel), .req_ready(rdy0),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .req_len(req_len), .rsp_valid(rv0), .rsp_err(re0),
        .rsp_rdata(rd0), .mem_addr(a0), .mem_cs_n(cs0), .mem_oe_n(oe0),
        .mem_we_n(we0), .mem_ub_n(ub0), .mem_lb_n(lb0), .mem_dq(dq0));
    psram_model m0 (.a(a0), .cs_n(cs0), .oe_n(oe0), .we_n(we0), .ub_n(ub0), .lb_n(lb0), .dq(dq0));

    psram_page_ctrl #(.T_MRC(100)) uut_short (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid && sel), .req_ready(rdy1),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .req_len(req_len), .rsp_valid(rv1), .rsp_err(re1),
        .rsp_rdata(rd1), .mem_addr(a1), .mem_cs_n(cs1), .mem_oe_n(oe1),
        .mem_we_n(we1), .mem_ub_n(ub1), .mem_lb_n(lb1), .mem_dq(dq1));
    psram_model m1 (.a(a1), .cs_n(cs1), .oe_n(oe1), .we_n(we1), .ub_n(ub1), .lb_n(lb1), .dq(dq1));

    localparam int FIRST = 7, PAGE = 3, WRC = 6, CP = 1, MRC_SHORT = 10;

    int checks = 0, fails = 0;
    logic [15:0] exp_mem [256];

    int n_cs_low, n_we_low, n_rsp, n_err, n_cs_fall, max_run, min_high;
    int bad_overlap, bad_ready, bad_hi, bad_release;
    int rsp_t [16];
    logic [15:0] rdat [16];

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic xact(input bit wr, input logic [22:0] ad, input logic [1:0] be,
                        input logic [15:0] wd, input logic [4:0] ln, input int n_exp);
        logic p_cs, p_we, p_oe, seen_low;
        logic [22:0] p_a;
        int run, hi, quiet;
        logic c_cs, c_oe, c_we, c_rv, c_re, c_rdy;
        logic [22:0] c_a;
        logic [15:0] c_rd;
        n_cs_low = 0; n_we_low = 0; n_rsp = 0; n_err = 0; n_cs_fall = 0;
        max_run = 0; min_high = 1000; bad_overlap = 0; bad_ready = 0;
        bad_hi = 0; bad_release = 0;
        p_cs = 1; p_we = 1; p_oe = 1; p_a = '0; seen_low = 0;
        run = 0; hi = 0; quiet = 0;
        @(negedge clk);
        req_write = wr; req_addr = ad; req_be = be; req_wdata = wd; req_len = ln;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int s = 1; s <= 300; s++) begin
            if (s > 1) @(negedge clk);
            c_cs = sel ? cs1 : cs0;  c_oe = sel ? oe1 : oe0;  c_we = sel ? we1 : we0;
            c_rv = sel ? rv1 : rv0;  c_re = sel ? re1 : re0;  c_rdy = sel ? rdy1 : rdy0;
            c_a  = sel ? a1 : a0;    c_rd = sel ? rd1 : rd0;
            if (c_rv) begin
                if (n_rsp < 16) begin rsp_t[n_rsp] = s; rdat[n_rsp] = c_rd; end
                n_rsp++;
                if (c_re) n_err++;
            end
            if (!c_cs) begin
                n_cs_low++;
                if (p_cs) begin
                    n_cs_fall++;
                    if (seen_low && hi < min_high) min_high = hi;
                end
                run++;
                if (run > max_run) max_run = run;
                hi = 0; seen_low = 1;
                if (!p_cs && c_a[22:4] != p_a[22:4]) bad_hi++;
                if (c_rdy) bad_ready++;
            end else begin
                run = 0; hi++;
            end
            if (!c_we) n_we_low++;
            if (!c_oe && !c_we) bad_overlap++;
            if (!c_oe && p_oe && !p_we) bad_release++;
            p_cs = c_cs; p_we = c_we; p_oe = c_oe; p_a = c_a;
            if (n_rsp >= n_exp && c_cs) begin
                quiet++;
                if (quiet >= 3) break;
            end
        end
    endtask

    task automatic bus_rules(input string tag);
        chk(bad_overlap == 0, {"R9 oe/we overlap ", tag}, bad_overlap, 0);
        chk(bad_release == 0, {"R9 bus release ", tag}, bad_release, 0);
        chk(bad_ready == 0, {"R10 ready while active ", tag}, bad_ready, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk({cs0, oe0, we0, ub0, lb0} == 5'b11111, "R11 strobes high", {cs0, oe0, we0, ub0, lb0}, 5'b11111);
        chk(rdy0 == 1'b1, "R11 ready", rdy0, 1);
        chk(rv0 == 1'b0, "R11 rsp_valid", rv0, 0);
    endtask

    task automatic t_read(input logic [22:0] ad, input logic [1:0] be);
        logic [15:0] exp;
        exp = exp_mem[ad[7:0]] & lane_mask(be);
        xact(1'b0, ad, be, 16'h0, 5'd1, 1);
        chk(n_rsp == 1 && n_err == 0, "R2 one good response", n_rsp, 1);
        chk(rdat[0] == exp, "R5 read data/lanes", rdat[0], exp);
        chk(rsp_t[0] == FIRST + 1, "R2 response latency", rsp_t[0], FIRST + 1);
        chk(n_cs_low == FIRST, "R2 cs low cycles", n_cs_low, FIRST);
        bus_rules("read");
    endtask

    task automatic t_burst(input logic [22:0] ad, input int ln);
        xact(1'b0, ad, 2'b11, 16'h0, 5'(ln), ln);
        chk(n_rsp == ln, "R3 word count", n_rsp, ln);
        for (int k = 0; k < ln; k++) begin
            logic [22:0] wa;
            wa = {ad[22:4], 4'(ad[3:0] + 4'(k))};
            chk(rdat[k] == exp_mem[wa[7:0]], "R3 burst word", rdat[k], exp_mem[wa[7:0]]);
            chk(rsp_t[k] == FIRST + 1 + PAGE * k, "R3 beat timing", rsp_t[k], FIRST + 1 + PAGE * k);
        end
        chk(n_cs_low == FIRST + PAGE * (ln - 1), "R3 cs low span", n_cs_low, FIRST + PAGE * (ln - 1));
        chk(bad_hi == 0, "R3 high address stable", bad_hi, 0);
        bus_rules("burst");
    endtask

    task automatic t_write(input logic [22:0] ad, input logic [1:0] be, input logic [15:0] wd);
        logic [15:0] m, exp;
        m = lane_mask(be);
        exp = (exp_mem[ad[7:0]] & ~m) | (wd & m);
        xact(1'b1, ad, be, wd, 5'd1, 1);
        chk(n_rsp == 1 && n_err == 0, "R4 write completion", n_err, 0);
        chk(rsp_t[0] == WRC + 2, "R4 completion time", rsp_t[0], WRC + 2);
        chk(n_we_low == WRC, "R4 we low cycles", n_we_low, WRC);
        chk(n_cs_low == WRC + 1, "R4 cs low cycles", n_cs_low, WRC + 1);
        bus_rules("write");
        exp_mem[ad[7:0]] = exp;
        xact(1'b0, ad, 2'b11, 16'h0, 5'd1, 1);
        chk(rdat[0] == exp, (be == 2'b00) ? "R6 abort leaves word" : "R5 write lanes",
            rdat[0], exp);
    endtask

    task automatic t_reject(input bit wr, input logic [22:0] ad, input logic [4:0] ln);
        xact(wr, ad, 2'b11, 16'h0, ln, 1);
        chk(n_rsp == 1 && n_err == 1, "R1 error response", n_err, 1);
        chk(rsp_t[0] == 1, "R1 error timing", rsp_t[0], 1);
        chk(n_cs_low == 0, "R1 no access", n_cs_low, 0);
    endtask

    task automatic t_split_burst();
        sel = 1'b1;
        xact(1'b0, 23'h000040, 2'b11, 16'h0, 5'd16, 16);
        chk(n_rsp == 16 && n_err == 0, "R8 all words returned", n_rsp, 16);
        for (int k = 0; k < 16; k++) begin
            chk(rdat[k] == exp_mem[8'h40 + 8'(k)], "R8 split burst word", rdat[k], exp_mem[8'h40 + 8'(k)]);
        end
        chk(max_run <= MRC_SHORT, "R8 cs run limit", max_run, MRC_SHORT);
        chk(n_cs_fall == 8, "R8 split count", n_cs_fall, 8);
        chk(min_high >= CP, "R7 cs high gap", min_high, CP);
        chk(rsp_t[2] == rsp_t[1] + CP + FIRST, "R8 full wait after split", rsp_t[2], rsp_t[1] + CP + FIRST);
        sel = 1'b0;
    endtask

    bit done = 0;
    initial begin
        #1000000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = 16'((i * 257) ^ 16'h5AC3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read(23'h000005, 2'b11);
        t_read(23'h7FFF06, 2'b01);
        t_read(23'h000007, 2'b10);
        t_burst(23'h000010, 16);
        t_burst(23'h123423, 5);
        t_burst(23'h00000C, 4);
        t_write(23'h000030, 2'b11, 16'hBEEF);
        t_write(23'h000031, 2'b10, 16'h12AB);
        t_write(23'h000032, 2'b00, 16'hFFFF);
        t_reject(1'b0, 23'h000000, 5'd0);
        t_reject(1'b0, 23'h000000, 5'd17);
        t_reject(1'b0, 23'h00000E, 5'd3);
        t_reject(1'b1, 23'h000000, 5'd2);
        t_split_burst();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule